// File: doc/BRIEF.md
# Overflow-flag carry-chain adder unit

This unit executes one step of a multi-precision addition. It adds a destination word, a source word and the current overflow flag of the flag register, which here serves as the incoming carry bit. The sum goes back to the destination, and the unsigned carry-out of that addition goes into the overflow flag. Every other flag bit leaves the unit exactly as it came in. A second carry chain that runs through the ordinary carry flag can therefore be interleaved with this one without the two disturbing each other.

Alongside the operands the unit receives the raw instruction bytes. It checks that they form the add-with-overflow opcode and finds out whether an operand-widening prefix promotes the operation to 64 bits. An invalid-opcode fault is raised when a lock prefix is present, when the capability enable is low, or when the bytes do not match the opcode. In all of these cases the destination and the flags are returned unchanged.

Software starts a chain by clearing the overflow flag itself. The unit never clears it on its own. The unit registers its results, so every accepted operation produces a one-cycle output strobe on the following clock.

Top module: `ofc_add_unit`

## Requirements
- R1: For an accepted operation, `result` equals `dest_in + src_in + flags_in[11]` truncated to the operation width. `flags_out[11]` equals the unsigned carry-out of that addition.
- R2: `flags_out` equals `flags_in` in every bit except bit 11. This includes carry (bit 0), parity (bit 2), auxiliary carry (bit 4), zero (bit 6) and sign (bit 7).
- R3: The instruction bytes are read from `op_bytes` with byte 0 in bits [7:0]. Apart from prefixes they must be F3, 0F, 38, F6 in that order, followed by an operand byte whose top two bits are 11 (register form). Any other sequence raises `fault_ud`.
- R4: A byte in the range 40..4F placed directly after F3 is a width prefix. If its bit 3 is set, the operation is 64 bits wide. If bit 3 is clear, the operation stays at the default 32 bits.
- R5: In 32-bit operation the carry-out is bit 32 of the sum, and `result[63:32]` is zero whatever `dest_in[63:32]` holds.
- R6: A byte F0 in position 0, ahead of F3, is a lock prefix. It raises `fault_ud`, `result` equals `dest_in`, and `flags_out` equals `flags_in`.
- R7: When `feat_en` is 0, `fault_ud` is raised, and `result` and `flags_out` are returned unchanged.
- R8: The incoming overflow flag is always added as given. A set flag adds one, and the unit never clears it implicitly.
- R9: `out_valid` is high exactly one clock after a cycle with `in_valid` high. `fault_ud` is only ever high together with `out_valid`.
- R10: While the reset is applied, `out_valid`, `fault_ud`, `result` and `flags_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_bytes | input | 64 | Instruction bytes, byte 0 in bits [7:0] |
| feat_en | input | 1 | Capability enable for the instruction |
| dest_in | input | 64 | Destination operand |
| src_in | input | 64 | Source operand |
| flags_in | input | 32 | Flag register before the operation |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| result | output | 64 | New destination value |
| flags_out | output | 32 | Flag register after the operation |
| fault_ud | output | 1 | Invalid-opcode fault strobe |

## Verification
The properties assume that `in_valid` is only raised after the internal reset synchronizer has released. They also assume that `op_bytes` carries at most one lock byte and at most one width prefix, each in its defined position. The stimulus waits several clocks after reset before its first operation. Every byte stream it sends is built by a helper that places the optional lock and width bytes only in those positions, and the unused tail bytes are padded with 90. Operands and flag words are random apart from the directed carry corner cases, so bits outside the overflow flag take both values.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
  localparam int unsigned FLG_OVF = 11;
  localparam int unsigned FLG_CRY = 0;
  localparam int unsigned FLG_PAR = 2;
  localparam int unsigned FLG_AUX = 4;
  localparam int unsigned FLG_ZER = 6;
  localparam int unsigned FLG_SGN = 7;

  localparam logic [7:0] BYTE_LOCK = 8'hF0;
  localparam logic [7:0] BYTE_MAND = 8'hF3;
  localparam logic [7:0] BYTE_ESC0 = 8'h0F;
  localparam logic [7:0] BYTE_ESC1 = 8'h38;
  localparam logic [7:0] BYTE_OPC  = 8'hF6;
  localparam logic [3:0] WPFX_HI   = 4'h4;
  localparam logic [1:0] MOD_REG   = 2'b11;

  typedef struct packed {
    logic legal;
    logic lock;
    logic wide;
  } dec_t;
endpackage

// File: rtl/ofc_decode.sv
module ofc_decode
  import ofc_pkg::*;
#(
  parameter int unsigned NB = 8
) (
  input  logic [NB*8-1:0] op_bytes,
  output dec_t            dec
);
  localparam int unsigned IW = $clog2(NB);

  logic [7:0] byt [NB];

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_split
      assign byt[gi] = op_bytes[gi*8 +: 8];
    end
  endgenerate

  logic [IW-1:0] p_idx;
  logic [IW-1:0] q_idx;
  logic          has_lock;
  logic          has_wpfx;
  logic          seq_ok;

  always_comb begin
    has_lock = (byt[0] == BYTE_LOCK);
    p_idx    = has_lock ? IW'(1) : IW'(0);
    has_wpfx = (byt[p_idx + IW'(1)][7:4] == WPFX_HI);
    q_idx    = p_idx + IW'(1) + (has_wpfx ? IW'(1) : IW'(0));
    seq_ok   = (byt[p_idx] == BYTE_MAND)
             && (byt[q_idx] == BYTE_ESC0)
             && (byt[q_idx + IW'(1)] == BYTE_ESC1)
             && (byt[q_idx + IW'(2)] == BYTE_OPC)
             && (byt[q_idx + IW'(3)][7:6] == MOD_REG);
    dec.legal = seq_ok;
    dec.lock  = has_lock;
    dec.wide  = has_wpfx && byt[p_idx + IW'(1)][3];
  end
endmodule

// File: rtl/ofc_adder.sv
module ofc_adder #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            cin,
  input  logic            wide,
  output logic [XLEN-1:0] sum,
  output logic            cout
);
  localparam int unsigned HW = XLEN / 2;

  logic [HW:0] lo_sum;
  logic [HW:0] hi_sum;

  always_comb begin
    lo_sum = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
    hi_sum = {1'b0, a[XLEN-1:HW]} + {1'b0, b[XLEN-1:HW]} + {{HW{1'b0}}, lo_sum[HW]};
    if (wide) begin
      sum  = {hi_sum[HW-1:0], lo_sum[HW-1:0]};
      cout = hi_sum[HW];
    end else begin
      sum  = {{HW{1'b0}}, lo_sum[HW-1:0]};
      cout = lo_sum[HW];
    end
  end
endmodule

// File: rtl/ofc_add_unit.sv
module ofc_add_unit
  import ofc_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned FLAGS_W = 32,
  parameter int unsigned NB      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [NB*8-1:0]    op_bytes,
  input  logic               feat_en,
  input  logic [XLEN-1:0]    dest_in,
  input  logic [XLEN-1:0]    src_in,
  input  logic [FLAGS_W-1:0] flags_in,
  output logic               out_valid,
  output logic [XLEN-1:0]    result,
  output logic [FLAGS_W-1:0] flags_out,
  output logic               fault_ud
);
  logic [1:0] rst_pipe;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  dec_t dec;
  logic is_wide;
  logic is_lock;

  ofc_decode #(.NB(NB)) u_dec (
    .op_bytes (op_bytes),
    .dec      (dec)
  );
  assign is_wide = dec.wide;
  assign is_lock = dec.lock;

  logic [XLEN-1:0] add_sum;
  logic            add_cout;

  ofc_adder #(.XLEN(XLEN)) u_add (
    .a    (dest_in),
    .b    (src_in),
    .cin  (flags_in[FLG_OVF]),
    .wide (is_wide),
    .sum  (add_sum),
    .cout (add_cout)
  );

  logic               ud_now;
  logic [XLEN-1:0]    res_d;
  logic [FLAGS_W-1:0] flg_d;
  logic               vld_d;
  logic               flt_d;

  always_comb begin
    ud_now = !dec.legal || dec.lock || !feat_en;
    vld_d  = in_valid;
    flt_d  = in_valid && ud_now;
    res_d  = dest_in;
    flg_d  = flags_in;
    if (!ud_now) begin
      res_d          = add_sum;
      flg_d[FLG_OVF] = add_cout;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_valid <= 1'b0;
      fault_ud  <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= vld_d;
      fault_ud  <= flt_d;
      if (in_valid) begin
        result    <= res_d;
        flags_out <= flg_d;
      end
    end
  end
endmodule

// File: rtl/ofc_add_unit_chk.sv
module ofc_add_unit_chk
  import ofc_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned FLAGS_W = 32
) (
  input logic               clk,
  input logic               rst_ok,
  input logic               in_valid,
  input logic               feat_en,
  input logic               is_wide,
  input logic               is_lock,
  input logic [XLEN-1:0]    dest_in,
  input logic [FLAGS_W-1:0] flags_in,
  input logic               out_valid,
  input logic [XLEN-1:0]    result,
  input logic [FLAGS_W-1:0] flags_out,
  input logic               fault_ud
);
  localparam logic [FLAGS_W-1:0] KEEP = ~(FLAGS_W'(1) << FLG_OVF);
  localparam int unsigned HW = XLEN / 2;

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);
  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid);
  assert_fault_in_window_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    fault_ud |-> out_valid);
  assert_keep_flags_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> ((flags_out & KEEP) == $past(flags_in & KEEP)));
  assert_no_feature_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !feat_en) |=> (fault_ud && result == $past(dest_in)));
  assert_lock_no_update_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && is_lock) |=> (fault_ud && result == $past(dest_in) && flags_out == $past(flags_in)));
  assert_narrow_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !is_wide && !is_lock && feat_en) |=> (fault_ud || result[XLEN-1:HW] == '0));
endmodule

bind ofc_add_unit ofc_add_unit_chk #(.XLEN(XLEN), .FLAGS_W(FLAGS_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .in_valid  (in_valid),
  .feat_en   (feat_en),
  .is_wide   (is_wide),
  .is_lock   (is_lock),
  .dest_in   (dest_in),
  .flags_in  (flags_in),
  .out_valid (out_valid),
  .result    (result),
  .flags_out (flags_out),
  .fault_ud  (fault_ud)
);

// File: tb/test_ofc_add_unit.sv
module test_ofc_add_unit;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] op_bytes;
  logic        feat_en;
  logic [63:0] dest_in;
  logic [63:0] src_in;
  logic [31:0] flags_in;
  logic        out_valid;
  logic [63:0] result;
  logic [31:0] flags_out;
  logic        fault_ud;

  int n_chk;
  int n_bad;

  ofc_add_unit i_ofc_add_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_bytes(op_bytes),
    .feat_en(feat_en), .dest_in(dest_in), .src_in(src_in), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .flags_out(flags_out), .fault_ud(fault_ud)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [31:0] KEEP = ~(32'h1 << 11);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_ops(bit lock, bit wpfx, logic [7:0] wbyte,
                                         logic [7:0] opc, logic [7:0] modrm);
    logic [63:0] v;
    int k;
    v = {8{8'h90}};
    k = 0;
    if (lock) begin v[8*k +: 8] = 8'hF0; k++; end
    v[8*k +: 8] = 8'hF3; k++;
    if (wpfx) begin v[8*k +: 8] = wbyte; k++; end
    v[8*k +: 8] = 8'h0F; k++;
    v[8*k +: 8] = 8'h38; k++;
    v[8*k +: 8] = opc;   k++;
    v[8*k +: 8] = modrm;
    return v;
  endfunction

  function automatic logic [64:0] ref_add(bit wide, logic [63:0] a, logic [63:0] b, bit c);
    logic [64:0] s;
    logic [32:0] n;
    if (wide) begin
      s = {1'b0, a} + {1'b0, b} + 65'(c);
      return s;
    end
    n = {1'b0, a[31:0]} + {1'b0, b[31:0]} + 33'(c);
    return {n[32], 32'h0, n[31:0]};
  endfunction

  task automatic run_op(input logic [63:0] ops, input bit en, input logic [63:0] d,
                        input logic [63:0] s, input logic [31:0] f);
    @(negedge clk);
    op_bytes = ops; feat_en = en; dest_in = d; src_in = s; flags_in = f;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_add(input string req, input bit wide, input logic [63:0] ops,
                         input logic [63:0] d, input logic [63:0] s, input logic [31:0] f);
    logic [64:0] e;
    e = ref_add(wide, d, s, f[11]);
    run_op(ops, 1'b1, d, s, f);
    chk(out_valid && !fault_ud, {req, " strobe"}, {62'h0, out_valid, fault_ud}, 64'h2);
    chk(result == e[63:0], {req, " sum"}, result, e[63:0]);
    chk(flags_out == ((f & KEEP) | (32'(e[64]) << 11)), {req, " flags R2"},
        64'(flags_out), 64'((f & KEEP) | (32'(e[64]) << 11)));
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    in_valid = 1'b0; op_bytes = '0; feat_en = 1'b0;
    dest_in = '0; src_in = '0; flags_in = '0;
    rst_n = 1'b0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!out_valid && !fault_ud && result == 0 && flags_out == 0, "R10 reset",
        result | 64'(flags_out) | {62'h0, out_valid, fault_ud}, 64'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R5 R2: 128-bit chain of four 32-bit words, carry flag toggled on the side
    begin
      logic [127:0] wa, wb;
      logic [128:0] ref128;
      logic [31:0]  fl;
      for (int i = 0; i < 4; i++) begin
        wa[32*i +: 32] = $urandom;
        wb[32*i +: 32] = $urandom;
      end
      wa[63:32] = 32'hFFFF_FFFF; wb[63:32] = 32'h0000_0001;
      ref128 = {1'b0, wa} + {1'b0, wb};
      fl = $urandom & KEEP;
      for (int i = 0; i < 4; i++) begin
        logic [31:0] fin;
        fin = fl;
        fin[0] = $urandom;
        run_op(mk_ops(0, 0, 8'h0, 8'hF6, 8'hC3), 1'b1, {$urandom, wa[32*i +: 32]},
               {$urandom, wb[32*i +: 32]}, fin);
        chk(result == {32'h0, ref128[32*i +: 32]}, "R1 R5 chain word", result,
            {32'h0, ref128[32*i +: 32]});
        chk(flags_out[0] == fin[0], "R2 carry flag untouched", 64'(flags_out[0]), 64'(fin[0]));
        fl = flags_out;
      end
      chk(fl[11] == ref128[128], "R1 chain final carry", 64'(fl[11]), 64'(ref128[128]));
    end

    // R4 R1: random 64-bit operations with W set
    for (int i = 0; i < 24; i++) begin
      logic [7:0] wb8;
      wb8 = {5'b01001, 3'($urandom)};
      chk_add("R4 wide", 1'b1, mk_ops(0, 1, wb8, 8'hF6, 8'hC0 | 8'($urandom % 64)),
              {$urandom, $urandom}, {$urandom, $urandom}, $urandom);
    end
    // R4: width prefix without W stays 32-bit
    for (int i = 0; i < 8; i++) begin
      chk_add("R4 narrow prefix", 1'b0, mk_ops(0, 1, {5'b01000, 3'($urandom)}, 8'hF6, 8'hD1),
              {$urandom, $urandom}, {$urandom, $urandom}, $urandom);
    end
    // R5: carry from bit 32, upper destination half discarded
    chk_add("R5 narrow wrap", 1'b0, mk_ops(0, 0, 8'h0, 8'hF6, 8'hC8),
            64'hDEAD_BEEF_FFFF_FFFF, 64'h0, 32'h0000_0800);
    // R8: set overflow flag is added, never cleared implicitly
    chk_add("R8 wide wrap", 1'b1, mk_ops(0, 1, 8'h48, 8'hF6, 8'hC8),
            64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'hFFFF_FFFF);
    chk_add("R8 zero plus one", 1'b1, mk_ops(0, 1, 8'h4F, 8'hF6, 8'hC0),
            64'h0, 64'h0, 32'h0000_08D5);
    chk_add("R1 no carry", 1'b0, mk_ops(0, 0, 8'h0, 8'hF6, 8'hFF),
            64'h7FFF_FFFF, 64'h1, 32'h0000_0001);

    // R6: lock prefix faults without update
    run_op(mk_ops(1, 0, 8'h0, 8'hF6, 8'hC1), 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1, 32'h0000_08C5);
    chk(fault_ud && out_valid, "R6 lock fault", 64'(fault_ud), 64'h1);
    chk(result == 64'h1234_5678_9ABC_DEF0 && flags_out == 32'h0000_08C5, "R6 lock no update",
        result, 64'h1234_5678_9ABC_DEF0);
    // R7: capability disabled
    run_op(mk_ops(0, 1, 8'h48, 8'hF6, 8'hC1), 1'b0, 64'hAAAA_0000_5555_0000, 64'h7, 32'h0000_0001);
    chk(fault_ud, "R7 feature off fault", 64'(fault_ud), 64'h1);
    chk(result == 64'hAAAA_0000_5555_0000 && flags_out == 32'h1, "R7 no update",
        result, 64'hAAAA_0000_5555_0000);
    // R3: wrong opcode byte and memory-form operand byte
    run_op(mk_ops(0, 0, 8'h0, 8'hF7, 8'hC0), 1'b1, 64'h5, 64'h6, 32'h0);
    chk(fault_ud && result == 64'h5, "R3 bad opcode", result, 64'h5);
    run_op(mk_ops(0, 0, 8'h0, 8'hF6, 8'h40), 1'b1, 64'h9, 64'h6, 32'h0);
    chk(fault_ud && result == 64'h9, "R3 memory form", result, 64'h9);
    run_op({8'h90, 8'h90, 8'hC0, 8'hF6, 8'h38, 8'h0F, 8'h66, 8'hF3}, 1'b1, 64'h3, 64'h4, 32'h0);
    chk(fault_ud, "R3 foreign prefix", 64'(fault_ud), 64'h1);

    // R9: strobe is one cycle wide
    @(negedge clk);
    chk(!out_valid && !fault_ud, "R9 idle after op", {62'h0, out_valid, fault_ud}, 64'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %h expected %h", 64'h1, 64'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule